// File: doc/BRIEF.md
# Split-Register Performance Counter Unit

This block counts processor activity for profiling. It holds one free-running cycle counter and four 32-bit event counters. Each event counter watches one line of an incoming event vector, and an 8-bit code picks that line. A small word-wide register port reads and writes every counter and the four configuration registers: control, interrupt enable, overflow flags and event select. The interrupt enable, the overflow flags and the event select each hold one field per counter.

Software starts and stops all counting with a single enable bit. It can also slow the cycle counter to one step per 64 clocks. When a counter wraps past all ones, it raises a sticky overflow flag. Any flag whose enable bit is set drives the interrupt output until software writes a one to clear the flag.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset every counter is 0, the interrupt enable and overflow flags are 0, the event select reads 0xFFFFFFFF, the control register reads UNIT_ID in bits 31:24 with all other bits 0, and irq is low.
- R2: Register map: 0 control, 1 cycle counter, 2 interrupt enable, 3 overflow flags, 4 event select, 5 to 8 event counters 0 to 3. In the control register, bit 0 (run) and bit 3 (slow cycle mode) are stored. Bits 1, 2 and 4 to 31 are not stored. A control read returns UNIT_ID in bits 31:24, run in bit 0, slow in bit 3 and zero elsewhere.
- R3: While run is 0, no counter changes except through a register write.
- R4: While run is 1 and slow is 0, the cycle counter adds one every clock. While run is 1 and slow is 1, it adds one on every 64th clock of a prescaler. That prescaler only advances while run and slow are both 1.
- R5: Event counter k adds one in a clock where run is 1, its code c is not 0xFF, c < EVT_LINES, and evt_in[c] is 1. A code of 0xFF, or a code of EVT_LINES or more, never counts.
- R6: The event select register holds the code for counter k in bits 8k+7:8k.
- R7: A control write with bit 1 set clears all four event counters. A control write with bit 2 set clears the cycle counter and its prescaler. Either clear overrides any increment in that clock.
- R8: Writing a counter's address loads the written value. The load overrides that counter's increment in the same clock and raises no overflow.
- R9: An increment from 0xFFFFFFFF wraps the counter to 0 and sets its overflow flag: bit 0 for the cycle counter, bit k+1 for event counter k. A flag stays set until it is cleared.
- R10: Writing the overflow flag register clears each flag whose written bit is 1. A wrap in the same clock keeps its flag set.
- R11: The interrupt enable register uses the same bit layout as the overflow flags. irq is high exactly when some flag and its enable bit are both 1.
- R12: Addresses 9 to 15 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_in | input | EVT_LINES | Event vector, one bit per event source |
| irq | output | 1 | Overflow interrupt |

## Verification
Reads are combinational from the registers. A write, a counted event or a wrap therefore shows on reg_rdata in the cycle after the clock edge that captures it. Overflow flags and irq also change one edge after the wrap.

The bench drives each cycle's stimulus just after a falling edge and compares reg_rdata and irq one time unit later. It then steps its behavioural model at the rising edge with the same stimulus. Every comparison therefore sees the state that the previous edge produced.

// File: rtl/perf_mon_unit.sv
module perf_mon_unit #(
  parameter int         EVT_LINES = 16,
  parameter int         CYC_DIV   = 64,
  parameter logic [7:0] UNIT_ID   = 8'h5C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [3:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [EVT_LINES-1:0] evt_in,
  output logic                 irq
);
  localparam int NEC  = 4;
  localparam int NCNT = NEC + 1;
  localparam int PW   = $clog2(CYC_DIV);
  localparam int IW   = (EVT_LINES > 1) ? $clog2(EVT_LINES) : 1;
  localparam logic [3:0] A_CTRL = 4'd0, A_CYC = 4'd1, A_IEN = 4'd2,
                         A_OVF  = 4'd3, A_SEL = 4'd4, A_EV0 = 4'd5;

  logic                  run, slow;
  logic [PW-1:0]         pre;
  logic [31:0]           sel;
  logic [NCNT-1:0]       ien, ovf, inc, load, wrap;
  logic [NCNT-1:0][31:0] cnt;

  wire ctrl_wr  = reg_we && (reg_addr == A_CTRL);
  wire pre_last = (pre == PW'(CYC_DIV - 1));
  wire [NCNT-1:0] clr = (reg_we && reg_addr == A_OVF) ? reg_wdata[NCNT-1:0] : '0;
  wire [31:0] ld_val  = ctrl_wr ? 32'd0 : reg_wdata;

  assign inc[0]  = run && (!slow || pre_last);
  assign load[0] = (reg_we && reg_addr == A_CYC) || (ctrl_wr && reg_wdata[2]);

  for (genvar k = 0; k < NEC; k++) begin : g_evt
    wire [7:0]    code = sel[8*k +: 8];
    wire [IW-1:0] line = code[IW-1:0];
    wire          hit  = (32'(code) < EVT_LINES) && evt_in[line];
    assign inc[k+1]  = run && (code != 8'hFF) && hit;
    assign load[k+1] = (reg_we && reg_addr == A_EV0 + 4'(k)) || (ctrl_wr && reg_wdata[1]);
  end

  for (genvar j = 0; j < NCNT; j++) begin : g_cnt
    logic [31:0] c;
    assign wrap[j] = inc[j] && !load[j] && (c == '1);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       c <= '0;
      else if (load[j]) c <= ld_val;
      else if (inc[j])  c <= c + 32'd1;
    assign cnt[j] = c;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run  <= 1'b0;
      slow <= 1'b0;
      pre  <= '0;
      sel  <= '1;
      ien  <= '0;
      ovf  <= '0;
    end else begin
      if (ctrl_wr) begin
        run  <= reg_wdata[0];
        slow <= reg_wdata[3];
      end
      if (ctrl_wr && reg_wdata[2]) pre <= '0;
      else if (run && slow)        pre <= pre_last ? '0 : pre + 1'b1;
      if (reg_we && reg_addr == A_SEL) sel <= reg_wdata;
      if (reg_we && reg_addr == A_IEN) ien <= reg_wdata[NCNT-1:0];
      ovf <= (ovf & ~clr) | wrap;
    end

  assign irq = |(ovf & ien);

  always_comb
    case (reg_addr)
      A_CTRL:  reg_rdata = {UNIT_ID, 20'd0, slow, 2'b00, run};
      A_CYC:   reg_rdata = cnt[0];
      A_IEN:   reg_rdata = 32'(ien);
      A_OVF:   reg_rdata = 32'(ovf);
      A_SEL:   reg_rdata = sel;
      4'd5:    reg_rdata = cnt[1];
      4'd6:    reg_rdata = cnt[2];
      4'd7:    reg_rdata = cnt[3];
      4'd8:    reg_rdata = cnt[4];
      default: reg_rdata = 32'd0;
    endcase

  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reg_we) |=> $stable(cnt));
  p_cyc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !slow && !reg_we) |=> (cnt[0] == $past(cnt[0]) + 32'd1));
  p_wrap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !slow && !reg_we && cnt[0] == '1) |=> (cnt[0] == '0 && ovf[0]));
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_OVF) |=> ((ovf & $past(ovf)) == $past(ovf)));
  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_OVF && !run) |=> ((ovf & $past(reg_wdata[NCNT-1:0])) == '0));
endmodule

// File: tb/tb_perf_mon_unit.sv
module tb_perf_mon_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ID = 8'h5C;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, irq;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [15:0] evt_in = '0;

  perf_mon_unit #(.EVT_LINES(16), .CYC_DIV(64), .UNIT_ID(ID)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  string cur = "R1";

  bit          m_en, m_div;
  int          m_pre;
  logic [31:0] m_cnt [5];
  logic [4:0]  m_ien, m_ovf;
  logic [31:0] m_sel;

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      4'd0: return {ID, 20'd0, m_div, 2'b00, m_en};
      4'd1: return m_cnt[0];
      4'd2: return {27'd0, m_ien};
      4'd3: return {27'd0, m_ovf};
      4'd4: return m_sel;
      4'd5, 4'd6, 4'd7, 4'd8: return m_cnt[a - 4];
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_reset();
    m_en = 0; m_div = 0; m_pre = 0; m_ien = 0; m_ovf = 0; m_sel = '1;
    for (int j = 0; j < 5; j++) m_cnt[j] = 0;
  endtask

  task automatic m_step(bit we, logic [3:0] a, logic [31:0] d, logic [15:0] e);
    bit inc [5];
    bit ld [5];
    logic [31:0] lv [5];
    logic [4:0] setf = 0, clrf = 0;
    bit ctl = we && a == 0;
    inc[0] = m_en && (!m_div || m_pre == 63);
    for (int k = 0; k < 4; k++) begin
      int code = m_sel[8*k +: 8];
      inc[k+1] = m_en && code != 255 && code < 16 && e[code % 16];
    end
    for (int j = 0; j < 5; j++) begin ld[j] = 0; lv[j] = 0; end
    if (we && a == 1) begin ld[0] = 1; lv[0] = d; end
    if (we && a >= 5 && a <= 8) begin ld[a-4] = 1; lv[a-4] = d; end
    if (ctl && d[2]) ld[0] = 1;
    if (ctl && d[1]) for (int k = 1; k < 5; k++) ld[k] = 1;
    for (int j = 0; j < 5; j++)
      if (ld[j]) m_cnt[j] = lv[j];
      else if (inc[j]) begin
        if (m_cnt[j] == 32'hFFFF_FFFF) setf[j] = 1;
        m_cnt[j] = m_cnt[j] + 1;
      end
    if (ctl && d[2]) m_pre = 0;
    else if (m_en && m_div) m_pre = (m_pre == 63) ? 0 : m_pre + 1;
    if (we && a == 3) clrf = d[4:0];
    m_ovf = (m_ovf & ~clrf) | setf;
    if (we && a == 2) m_ien = d[4:0];
    if (we && a == 4) m_sel = d;
    if (ctl) begin m_en = d[0]; m_div = d[3]; end
  endtask

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", cur, what, act, exp);
    end
  endtask

  task automatic tick(bit we, logic [3:0] a, logic [31:0] d, logic [15:0] e);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; evt_in = e;
    #1;
    check($sformatf("rdata@%0d", a), reg_rdata, m_read(a));
    check("irq", {31'd0, irq}, {31'd0, (|(m_ovf & m_ien))});
    @(posedge clk);
    m_step(we, a, d, e);
  endtask

  task automatic rd(logic [3:0] a, int n = 1);
    for (int i = 0; i < n; i++) tick(0, a, 32'd0, 16'd0);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    tick(1, a, d, 16'd0);
  endtask

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state on every address
    cur = "R1";
    for (int a = 0; a < 16; a++) rd(4'(a));
    // R2 control storage and readback
    cur = "R2";
    wr(0, 32'hFFFF_FFF6); rd(0, 2);
    wr(0, 32'h0000_0000); rd(0);
    // R3 nothing counts while run is clear
    cur = "R3";
    wr(4, 32'h0302_0100);
    for (int i = 0; i < 12; i++) tick(0, 4'(5 + i % 4), 32'd0, 16'hFFFF);
    rd(1, 3);
    // R4 cycle counter full speed then slow
    cur = "R4";
    wr(0, 32'h1); rd(1, 10);
    wr(0, 32'hD); rd(1, 140);
    wr(0, 32'h0); rd(1, 3);
    // R5 R6 event routing incl. disabled and out-of-range codes
    cur = "R5_R6";
    wr(4, 32'hFF14_0300); rd(4);
    wr(0, 32'h3);
    for (int i = 0; i < 60; i++)
      tick(0, 4'(5 + i % 4), 32'd0, 16'((i * 37) ^ (i << 3)));
    wr(4, 32'h0F00_0105);
    for (int i = 0; i < 40; i++)
      tick(0, 4'(5 + i % 4), 32'd0, 16'((i * 91) ^ 16'hA5A5));
    // R7 selective clears through the control register
    cur = "R7";
    wr(0, 32'h3); rd(1, 2); rd(5); rd(8);
    for (int i = 0; i < 5; i++) tick(0, 5, 0, 16'hFFFF);
    wr(0, 32'h5); rd(1, 2); rd(6, 2);
    // R8 direct counter loads, also while counting
    cur = "R8";
    for (int i = 0; i < 4; i++) tick(1, 4'(5 + i), 32'h1000_0000 * (i + 1), 16'hFFFF);
    for (int i = 0; i < 8; i++) tick(0, 4'(5 + i % 4), 32'd0, 16'hFFFF);
    wr(1, 32'h0000_0077); rd(1, 2);
    // R9 wraps on cycle and event counters
    cur = "R9";
    wr(1, 32'hFFFF_FFFD); rd(1, 4); rd(3, 2);
    tick(1, 6, 32'hFFFF_FFFF, 16'hFFFF);
    tick(0, 6, 0, 16'hFFFF); rd(3, 3);
    // R10 W1C and same-cycle set priority
    cur = "R10";
    wr(3, 32'h0000_0001); rd(3);
    wr(1, 32'hFFFF_FFFF);
    wr(3, 32'h0000_001F); rd(3, 2);
    wr(3, 32'h0000_001F); rd(3);
    // R11 interrupt gating
    cur = "R11";
    wr(0, 32'h0);
    wr(1, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
    wr(0, 32'h1); wr(0, 32'h0);
    rd(3); rd(2);
    wr(2, 32'h0000_0008); rd(2, 2);
    wr(2, 32'h0000_0001); rd(3, 2);
    wr(3, 32'h0000_0001); rd(3, 2);
    wr(2, 32'hFFFF_FFFF); rd(2);
    wr(3, 32'h0000_001F); rd(3, 2);
    // R12 unmapped addresses
    cur = "R12";
    for (int a = 9; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF);
    for (int a = 0; a < 16; a++) rd(4'(a));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule